// File: doc/BRIEF.md
# Level Priority Interrupt Controller

This block gathers interrupt requests from three active-low external pins and a parameterised set of internal peripheral sources. It reduces them to one winning request and presents that request's level (1 to 7) to the processor core. Each source has a level, a two-bit priority step within that level, a mask bit and an autovector select. The external pins work in one of two modes. In fixed mode each pin is its own source at a hard-wired level. In encoded mode the three pins together carry a single level.

When the core pulses its acknowledge, the block returns a response on the next cycle. The response names the winning source and its level. It also either gives an autovector number or tells the core to fetch the vector from the requesting device. If nothing is being presented at that moment, the response is marked spurious. The core's current mask level is an input: levels at or below it are held back, except level 7, which always gets through. The core's exception handling and the timing of the bus acknowledge cycle are outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, ipl_out and every response output are cleared to zero on that edge.
- R2: External pins pass through two synchroniser flops. A pin that goes low before clock edge k changes ipl_out at edge k+2. An internal request present before edge k changes ipl_out at edge k.
- R3: In fixed mode (enc_mode = 0), ext_irq_n[0], [1] and [2] each request when low. They are sources 0, 1 and 2, at levels 1, 4 and 7. Each uses its own two-bit slice of ext_prio and its own bit of ext_mask and ext_autovec.
- R4: In encoded mode (enc_mode = 1), the level is the bitwise inverse of the three synchronised pins, and 3'b111 on the pins means no request. This single request is source 0 and uses ext_prio[1:0], ext_mask[0] and ext_autovec[0]. Sources 1 and 2 are idle.
- R5: The eligible source with the highest level wins. Internal source j is source index 3+j, with level int_level[3j+2:3j] and priority int_prio[2j+1:2j].
- R6: Among eligible sources at the same level, the larger priority step wins. Any tie left after that goes to the lowest source index.
- R7: A source whose mask bit is 1, or whose level is 0, never takes part in arbitration.
- R8: The winner's level appears on ipl_out only when it is 7 or greater than core_mask; otherwise ipl_out is 0.
- R9: An ack sampled at an edge with a presented winner sets rsp_valid on that edge with rsp_level and rsp_src of that winner. If the winner's autovector bit is 1, rsp_autovec = 1 and rsp_vector = 24 + level. Otherwise rsp_autovec = 0 and rsp_vector = 0 (the device supplies the vector).
- R10: An ack sampled while nothing is presented gives rsp_valid = 1, rsp_spurious = 1, rsp_autovec = 0, rsp_vector = 24 and rsp_level = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_irq_n | input | 3 | External interrupt pins, active low, asynchronous |
| enc_mode | input | 1 | 1: pins carry an encoded level; 0: fixed levels 1/4/7 |
| ext_prio | input | 6 | Two-bit priority step per external source |
| ext_mask | input | 3 | Mask bit per external source (1 = excluded) |
| ext_autovec | input | 3 | Autovector select per external source |
| int_req | input | N_INT | Internal peripheral requests, active high |
| int_level | input | 3*N_INT | Level per internal source (0 disables it) |
| int_prio | input | 2*N_INT | Priority step per internal source |
| int_mask | input | N_INT | Mask bit per internal source |
| int_autovec | input | N_INT | Autovector select per internal source |
| core_mask | input | 3 | Current interrupt mask level of the core |
| ack | input | 1 | Interrupt acknowledge strobe from the core |
| ipl_out | output | 3 | Presented interrupt level, 0 when none |
| rsp_valid | output | 1 | Acknowledge response valid |
| rsp_spurious | output | 1 | Nothing was pending at acknowledge |
| rsp_autovec | output | 1 | Response carries an autovector |
| rsp_vector | output | 8 | Autovector number, 24 for spurious, else 0 |
| rsp_level | output | 3 | Level of the acknowledged source |
| rsp_src | output | IDX_W | Index of the acknowledged source |

## Verification
The assertions check, on every cycle, that a presented level below 7 is above the core mask of the previous cycle and that the arbitration winner is never a masked or idle source. They also check that a response only follows an acknowledge, that an autovector equals 24 plus the reported level, and that a spurious response has its fixed form. Only the bench's scenarios can show which source actually wins: the level, priority-step and lowest-index ordering, the fixed and encoded pin interpretation, and the exact two-cycle pin latency. The bench shows these by comparing against a behavioural model on every clock.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the level priority interrupt controller.
// Assumes levels are 3 bits wide and priority steps 2 bits wide.
package irqc_pkg;
    localparam int          LVL_W        = 3;
    localparam int          PRIO_W       = 2;
    localparam int          N_EXT        = 3;
    localparam logic [7:0]  AUTOVEC_BASE = 8'd24;
    localparam logic [2:0]  NMI_LEVEL    = 3'd7;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [PRIO_W-1:0] prio_t;

    // Hard-wired level of external pin i in fixed mode.
    function automatic lvl_t fixed_pin_level(input int i);
        case (i)
            0:       return 3'd1;
            1:       return 3'd4;
            default: return 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/irqc_pin_sync.sv
// Multi-stage synchroniser for asynchronous active-low request pins.
// Assumes the idle level of every pin is high; reset loads all ones.
module irqc_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '1;
                else        stage_q[0] <= din;
            end
        end else begin : g_next
            // Later stages shift the sampled value along.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_ext_decode.sv
// Turns the synchronised external pins into per-source requests, levels
// and priority steps. Fixed mode: one source per pin at levels 1/4/7.
// Encoded mode: the inverted pins form one level on source 0.
module irqc_ext_decode
    import irqc_pkg::*;
(
    input  logic [N_EXT-1:0]        pins_n,
    input  logic                    enc_mode,
    input  logic [PRIO_W*N_EXT-1:0] ext_prio,
    output logic [N_EXT-1:0]        src_req,
    output logic [LVL_W*N_EXT-1:0]  src_lvl,
    output logic [PRIO_W*N_EXT-1:0] src_prio
);
    lvl_t enc_level;

    // Active-low pins: inverting them gives the encoded level, 0 = idle.
    assign enc_level = ~pins_n;

    for (genvar g = 0; g < N_EXT; g++) begin : g_src
        if (g == 0) begin : g_shared
            // Source 0 carries either pin 0 or the whole encoded level.
            always_comb begin
                if (enc_mode) begin
                    src_req[0]          = (enc_level != 3'd0);
                    src_lvl[LVL_W-1:0]  = enc_level;
                end else begin
                    src_req[0]          = ~pins_n[0];
                    src_lvl[LVL_W-1:0]  = fixed_pin_level(0);
                end
            end
        end else begin : g_fixed
            // Sources 1 and 2 exist only in fixed mode.
            always_comb begin
                src_req[g]                 = ~enc_mode & ~pins_n[g];
                src_lvl[g*LVL_W +: LVL_W]  = fixed_pin_level(g);
            end
        end
        assign src_prio[g*PRIO_W +: PRIO_W] = ext_prio[g*PRIO_W +: PRIO_W];
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Combinational winner selection over NSRC sources: highest level first,
// then highest priority step, then lowest index. Masked or level-0
// sources are excluded.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]        req,
    input  logic [NSRC-1:0]        mask,
    input  logic [LVL_W*NSRC-1:0]  lvl_flat,
    input  logic [PRIO_W*NSRC-1:0] prio_flat,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx,
    output lvl_t                   win_lvl
);
    logic [NSRC-1:0] elig;
    prio_t           win_prio;
    lvl_t            cur_l;
    prio_t           cur_p;

    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        assign elig[g] = req[g] & ~mask[g] & (lvl_flat[g*LVL_W +: LVL_W] != 3'd0);
    end

    // Ascending scan with strict comparison keeps the lowest index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        win_prio  = '0;
        cur_l     = '0;
        cur_p     = '0;
        for (int i = 0; i < NSRC; i++) begin
            cur_l = lvl_flat[i*LVL_W +: LVL_W];
            cur_p = prio_flat[i*PRIO_W +: PRIO_W];
            if (elig[i] && (!win_valid || (cur_l > win_lvl) ||
                            ((cur_l == win_lvl) && (cur_p > win_prio)))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = cur_l;
                win_prio  = cur_p;
            end
        end
    end
endmodule

// File: rtl/irqc_ack_resp.sv
// Registers the acknowledge response: the winner with an autovector or
// a device-vector cue, or a spurious indication when nothing is presented.
module irqc_ack_resp
    import irqc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             present,
    input  logic [IDX_W-1:0] win_idx,
    input  lvl_t             win_lvl,
    input  logic             win_autovec,
    output logic             rsp_valid,
    output logic             rsp_spurious,
    output logic             rsp_autovec,
    output logic [7:0]       rsp_vector,
    output lvl_t             rsp_level,
    output logic [IDX_W-1:0] rsp_src
);
    // Response fields are pulsed for one cycle per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !ack) begin
            rsp_valid    <= 1'b0;
            rsp_spurious <= 1'b0;
            rsp_autovec  <= 1'b0;
            rsp_vector   <= '0;
            rsp_level    <= '0;
            rsp_src      <= '0;
        end else if (present) begin
            rsp_valid    <= 1'b1;
            rsp_spurious <= 1'b0;
            rsp_autovec  <= win_autovec;
            rsp_vector   <= win_autovec ? (AUTOVEC_BASE + {5'd0, win_lvl}) : 8'd0;
            rsp_level    <= win_lvl;
            rsp_src      <= win_idx;
        end else begin
            rsp_valid    <= 1'b1;
            rsp_spurious <= 1'b1;
            rsp_autovec  <= 1'b0;
            rsp_vector   <= AUTOVEC_BASE;
            rsp_level    <= '0;
            rsp_src      <= '0;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the level priority interrupt controller. Combines synchronised
// external pins and internal requests, arbitrates them, presents the
// winning level against the core mask and answers acknowledges.
// Assumes ack is a one-cycle strobe synchronous to clk.
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter  int N_INT       = 5,
    parameter  int SYNC_STAGES = 2,
    localparam int N_SRC       = N_EXT + N_INT,
    localparam int IDX_W       = $clog2(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EXT-1:0]        ext_irq_n,
    input  logic                    enc_mode,
    input  logic [PRIO_W*N_EXT-1:0] ext_prio,
    input  logic [N_EXT-1:0]        ext_mask,
    input  logic [N_EXT-1:0]        ext_autovec,
    input  logic [N_INT-1:0]        int_req,
    input  logic [LVL_W*N_INT-1:0]  int_level,
    input  logic [PRIO_W*N_INT-1:0] int_prio,
    input  logic [N_INT-1:0]        int_mask,
    input  logic [N_INT-1:0]        int_autovec,
    input  logic [LVL_W-1:0]        core_mask,
    input  logic                    ack,
    output logic [LVL_W-1:0]        ipl_out,
    output logic                    rsp_valid,
    output logic                    rsp_spurious,
    output logic                    rsp_autovec,
    output logic [7:0]              rsp_vector,
    output logic [LVL_W-1:0]        rsp_level,
    output logic [IDX_W-1:0]        rsp_src
);
    logic [N_EXT-1:0]        pins_sync_n;
    logic [N_EXT-1:0]        ext_req;
    logic [LVL_W*N_EXT-1:0]  ext_lvl;
    logic [PRIO_W*N_EXT-1:0] ext_prio_src;

    logic [N_SRC-1:0]        req_all;
    logic [N_SRC-1:0]        mask_all;
    logic [N_SRC-1:0]        autovec_all;
    logic [LVL_W*N_SRC-1:0]  lvl_all;
    logic [PRIO_W*N_SRC-1:0] prio_all;

    logic                    win_valid;
    logic [IDX_W-1:0]        win_idx;
    lvl_t                    win_lvl;
    logic                    present;

    irqc_pin_sync #(.WIDTH(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_irq_n),
        .dout  (pins_sync_n)
    );

    irqc_ext_decode u_decode (
        .pins_n   (pins_sync_n),
        .enc_mode (enc_mode),
        .ext_prio (ext_prio),
        .src_req  (ext_req),
        .src_lvl  (ext_lvl),
        .src_prio (ext_prio_src)
    );

    // External sources take the low indices, internal ones follow.
    assign req_all     = {int_req,     ext_req};
    assign mask_all    = {int_mask,    ext_mask};
    assign autovec_all = {int_autovec, ext_autovec};
    assign lvl_all     = {int_level,   ext_lvl};
    assign prio_all    = {int_prio,    ext_prio_src};

    irqc_arbiter #(.NSRC(N_SRC), .IDX_W(IDX_W)) u_arb (
        .req       (req_all),
        .mask      (mask_all),
        .lvl_flat  (lvl_all),
        .prio_flat (prio_all),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    // Level 7 bypasses the core mask; all others must exceed it.
    assign present = win_valid && ((win_lvl == NMI_LEVEL) || (win_lvl > core_mask));

    // Registered level presented to the core.
    always_ff @(posedge clk) begin
        if (!rst_n)       ipl_out <= '0;
        else if (present) ipl_out <= win_lvl;
        else              ipl_out <= '0;
    end

    irqc_ack_resp #(.IDX_W(IDX_W)) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack          (ack),
        .present      (present),
        .win_idx      (win_idx),
        .win_lvl      (win_lvl),
        .win_autovec  (autovec_all[win_idx]),
        .rsp_valid    (rsp_valid),
        .rsp_spurious (rsp_spurious),
        .rsp_autovec  (rsp_autovec),
        .rsp_vector   (rsp_vector),
        .rsp_level    (rsp_level),
        .rsp_src      (rsp_src)
    );

    AST_IPL_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_out != 3'd0 && ipl_out != NMI_LEVEL) |-> (ipl_out > $past(core_mask))); // R8
    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (req_all[win_idx] && !mask_all[win_idx])); // R7
    AST_RSP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(ack)); // R9
    AST_AUTOVEC_NUM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_autovec) |-> (rsp_vector == AUTOVEC_BASE + {5'd0, rsp_level} && rsp_level != 3'd0)); // R9
    AST_RSP_MATCH_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_spurious) |-> (rsp_level == ipl_out)); // R9
    AST_SPURIOUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_spurious) |-> (rsp_vector == AUTOVEC_BASE && rsp_level == 3'd0 && !rsp_autovec)); // R10
    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_spurious, rsp_autovec})); // R10
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
    localparam int N_INT = 5;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [2:0]           ext_irq_n;
    logic                 enc_mode;
    logic [5:0]           ext_prio;
    logic [2:0]           ext_mask;
    logic [2:0]           ext_autovec;
    logic [N_INT-1:0]     int_req;
    logic [3*N_INT-1:0]   int_level;
    logic [2*N_INT-1:0]   int_prio;
    logic [N_INT-1:0]     int_mask;
    logic [N_INT-1:0]     int_autovec;
    logic [2:0]           core_mask;
    logic                 ack;
    logic [2:0]           ipl_out;
    logic                 rsp_valid, rsp_spurious, rsp_autovec;
    logic [7:0]           rsp_vector;
    logic [2:0]           rsp_level;
    logic [2:0]           rsp_src;

    int    compared = 0;
    int    mismatched = 0;
    string cur_tag = "R1";
    bit    model_ready = 0;
    bit    finished = 0;

    irq_prio_ctrl #(.N_INT(N_INT)) uut (
        .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .enc_mode(enc_mode),
        .ext_prio(ext_prio), .ext_mask(ext_mask), .ext_autovec(ext_autovec),
        .int_req(int_req), .int_level(int_level), .int_prio(int_prio),
        .int_mask(int_mask), .int_autovec(int_autovec), .core_mask(core_mask),
        .ack(ack), .ipl_out(ipl_out), .rsp_valid(rsp_valid),
        .rsp_spurious(rsp_spurious), .rsp_autovec(rsp_autovec),
        .rsp_vector(rsp_vector), .rsp_level(rsp_level), .rsp_src(rsp_src)
    );

    always #4 clk = ~clk;

    // Behavioural reference state.
    int m_pins[$];
    int m_ipl, m_rv, m_rs, m_ra, m_vec, m_lvl, m_src;

    task automatic pick(input int pins, output bit v, output int idx,
                        output int lvl, output bit av);
        v = 0; idx = 0; lvl = 0; av = 0;
        begin
            int best_p = 0;
            for (int i = 0; i < 3 + N_INT; i++) begin
                bit rq; int l; int p; bit mk; bit a;
                if (i < 3) begin
                    if (enc_mode) begin
                        l  = (i == 0) ? (7 - pins) : 0;
                        rq = (i == 0) && (l != 0);
                    end else begin
                        rq = ((pins >> i) & 1) == 0;
                        l  = (i == 0) ? 1 : (i == 1) ? 4 : 7;
                    end
                    p = int'(ext_prio[2*i +: 2]); mk = ext_mask[i]; a = ext_autovec[i];
                end else begin
                    rq = int_req[i-3]; l = int'(int_level[3*(i-3) +: 3]);
                    p = int'(int_prio[2*(i-3) +: 2]); mk = int_mask[i-3]; a = int_autovec[i-3];
                end
                if (rq && !mk && l != 0 && (!v || l > lvl || (l == lvl && p > best_p))) begin
                    v = 1; idx = i; lvl = l; best_p = p; av = a;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        bit v; int idx; int lvl; bit av; bit pres;
        model_ready <= 1;
        if (!rst_n) begin
            m_pins = '{7, 7};
            m_ipl = 0; m_rv = 0; m_rs = 0; m_ra = 0; m_vec = 0; m_lvl = 0; m_src = 0;
        end else begin
            pick(m_pins[0], v, idx, lvl, av);
            pres = v && (lvl == 7 || lvl > int'(core_mask));
            m_ipl = pres ? lvl : 0;
            if (!ack) begin
                m_rv = 0; m_rs = 0; m_ra = 0; m_vec = 0; m_lvl = 0; m_src = 0;
            end else if (pres) begin
                m_rv = 1; m_rs = 0; m_ra = av; m_vec = av ? 24 + lvl : 0; m_lvl = lvl; m_src = idx;
            end else begin
                m_rv = 1; m_rs = 1; m_ra = 0; m_vec = 24; m_lvl = 0; m_src = 0;
            end
            void'(m_pins.pop_front());
            m_pins.push_back(int'(ext_irq_n));
        end
    end

    // Compare every output against the model once per clock, mid-cycle.
    always @(negedge clk) begin
        if (model_ready && !finished) begin
            compared++;
            if (int'(ipl_out) != m_ipl || int'(rsp_valid) != m_rv || int'(rsp_spurious) != m_rs ||
                int'(rsp_autovec) != m_ra || int'(rsp_vector) != m_vec ||
                int'(rsp_level) != m_lvl || int'(rsp_src) != m_src) begin
                mismatched++;
                $display("FAIL %s model: ipl=%0d v=%0d s=%0d a=%0d vec=%0d lvl=%0d src=%0d expected ipl=%0d v=%0d s=%0d a=%0d vec=%0d lvl=%0d src=%0d",
                         cur_tag, ipl_out, rsp_valid, rsp_spurious, rsp_autovec, rsp_vector,
                         rsp_level, rsp_src, m_ipl, m_rv, m_rs, m_ra, m_vec, m_lvl, m_src);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic quiet();
        enc_mode = 0; ext_irq_n = 3'b111; ext_prio = '0; ext_mask = '0; ext_autovec = 3'b111;
        int_req = '0; int_level = '0; int_prio = '0; int_mask = '0; int_autovec = '0;
        core_mask = 3'd0; ack = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL R1: watchdog expired, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        quiet();
        rst_n = 1'b0;
        tick(3);
        cur_tag = "R1";
        check("R1 ipl after reset", int'(ipl_out), 0);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        tick(1);

        // R2: two synchroniser stages plus the level register.
        cur_tag = "R2";
        ext_irq_n = 3'b011;
        tick(1); check("R2 edge 1", int'(ipl_out), 0);
        tick(1); check("R2 edge 2", int'(ipl_out), 0);
        tick(1); check("R2 edge 3", int'(ipl_out), 7);
        ext_irq_n = 3'b111; tick(3);
        int_req[0] = 1; int_level[2:0] = 3'd2;
        tick(1); check("R2 internal one edge", int'(ipl_out), 2);
        quiet(); tick(3);

        // R3: fixed pin levels.
        cur_tag = "R3";
        ext_irq_n = 3'b110; tick(3);
        check("R3 pin0 level", int'(ipl_out), 1);
        ext_irq_n = 3'b100; tick(3);
        check("R3 pin1 level", int'(ipl_out), 4);
        do_ack();
        check("R3 ack src", int'(rsp_src), 1);
        check("R9 autovector 24+4", int'(rsp_vector), 28);

        // R4: encoded mode.
        cur_tag = "R4";
        enc_mode = 1; ext_irq_n = 3'b010; tick(3);
        check("R4 encoded level 5", int'(ipl_out), 5);
        do_ack();
        check("R4 encoded src", int'(rsp_src), 0);
        check("R9 encoded autovector", int'(rsp_vector), 29);
        ext_irq_n = 3'b111; tick(3);
        check("R4 all-high idle", int'(ipl_out), 0);
        quiet(); tick(3);

        // R5: highest level wins; device-vector response.
        cur_tag = "R5";
        ext_irq_n = 3'b101; int_req[0] = 1; int_level[2:0] = 3'd6; tick(3);
        check("R5 level 6 over 4", int'(ipl_out), 6);
        do_ack();
        check("R5 winner src", int'(rsp_src), 3);
        check("R9 device vector flag", int'(rsp_autovec), 0);
        check("R9 device vector field", int'(rsp_vector), 0);
        quiet(); tick(3);

        // R6: priority step, then lowest index.
        cur_tag = "R6";
        int_req = 5'b00110; int_level[5:3] = 3'd3; int_level[8:6] = 3'd3;
        int_prio[3:2] = 2'd1; int_prio[5:4] = 2'd2; tick(2);
        do_ack();
        check("R6 higher step wins", int'(rsp_src), 5);
        int_prio[3:2] = 2'd2; tick(1);
        do_ack();
        check("R6 tie lowest index", int'(rsp_src), 4);

        // R7: masked sources and level-0 sources are ignored.
        cur_tag = "R7";
        int_mask[1] = 1; int_req[3] = 1; int_prio[7:6] = 2'd3; tick(1);
        do_ack();
        check("R7 masked skipped", int'(rsp_src), 5);
        int_mask[2] = 1; tick(2);
        check("R7 all masked idle", int'(ipl_out), 0);
        quiet(); tick(3);

        // R8: core mask gate and level 7 bypass.
        cur_tag = "R8";
        core_mask = 3'd4; int_req[0] = 1; int_level[2:0] = 3'd4; tick(2);
        check("R8 equal to mask held", int'(ipl_out), 0);
        int_level[2:0] = 3'd5; tick(2);
        check("R8 above mask shown", int'(ipl_out), 5);
        core_mask = 3'd7; int_level[2:0] = 3'd6; ext_irq_n = 3'b011; tick(3);
        check("R8 level 7 bypass", int'(ipl_out), 7);
        ext_irq_n = 3'b111; tick(3);
        check("R8 level 6 under mask 7", int'(ipl_out), 0);

        // R10: spurious acknowledge.
        cur_tag = "R10";
        do_ack();
        check("R10 spurious flag", int'(rsp_spurious), 1);
        check("R10 spurious vector", int'(rsp_vector), 24);
        quiet(); tick(2);
        do_ack();
        check("R10 idle spurious", int'(rsp_spurious), 1);
        tick(2);

        // Random traffic compared against the model (R5 R6 R7 R9).
        cur_tag = "R9";
        for (int c = 0; c < 600; c++) begin
            if ($urandom_range(0, 7) == 0) ext_irq_n = 3'($urandom);
            if ($urandom_range(0, 31) == 0) enc_mode = ~enc_mode;
            ext_prio = 6'($urandom); ext_mask = 3'($urandom) & 3'($urandom);
            ext_autovec = 3'($urandom);
            int_req = 5'($urandom); int_level = 15'($urandom); int_prio = 10'($urandom);
            int_mask = 5'($urandom) & 5'($urandom); int_autovec = 5'($urandom);
            core_mask = 3'($urandom);
            ack = ($urandom_range(0, 3) == 0);
            tick(1);
        end
        ack = 0;
        tick(2);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule